// File: doc/BRIEF.md
# Dual-Length Instruction Decoder

This block turns one fetched 32-bit word of a small 16-bit RISC core with sixteen registers into the fields and control bundle that the later pipeline stages consume. The word is little endian, so the opcode is its lowest byte. The opcode value alone decides whether the word is a short two-register instruction or a long instruction that carries a 16-bit immediate in its upper half.

Decoding is purely combinational. A parameter places an optional register stage on the outputs so that the decoder can form the decode stage of a four-stage pipeline. Three sub-blocks do the work:
- a field splitter that extracts the length and the fields;
- a control mapper that turns the opcode into one-hot selects and strobes;
- an output stage that is either a plain wire or a reset-cleared register.

Top module: `dual_len_decoder`

## Requirements
- R1: `is_long` is 1 exactly when the opcode byte (word bits 7:0) is 0x20 or above, including undefined opcodes.
- R2: `opcode` equals word bits 7:0, `reg_a` equals bits 11:8, and `reg_b` equals bits 15:12 (second register or port number). `imm` equals bits 31:16 for a long word and is 0 for a short word.
- R3: `alu_sel` is one-hot or zero, with this bit order: 0 copy 0x01, 1 and 0x02, 2 or 0x03, 3 invert 0x04, 4 xor 0x05, 5 add 0x06, 6 add-with-carry 0x13, 7 subtract 0x07, 8 subtract-with-borrow 0x14, 9 increment 0x08, 10 decrement 0x09, 11 negate 0x15, 12 shift-left 0x0A, 13 shift-right 0x0B, 14 arithmetic-left 0x16, 15 arithmetic-right 0x17, 16 rotate-left 0x0C, 17 rotate-right 0x0D, 18 compare 0x0E, 19 link 0x19, 20 load-constant 0x20. All other opcodes give 0.
- R4: `reg_we` is 0 for compare 0x0E, store 0x10, port output 0x12, no-op 0x00, the register jump 0x18, the jumps 0x21 to 0x27, and every undefined opcode. It is 1 for every other defined opcode.
- R5: memory load 0x0F raises only `mem_rd` among the side-effect strobes. Memory store 0x10 raises only `mem_wr`.
- R6: port input 0x11 raises `port_in`, and port output 0x12 raises `port_out`.
- R7: `jump_sel` is one-hot or zero, with this bit order: 0 register target 0x18, 1 unconditional 0x21, 2 on zero 0x22, 3 on not-zero 0x23, 4 on lesser 0x24, 5 on not-lesser 0x25, 6 on greater 0x26, 7 on not-greater 0x27.
- R8: opcodes 0x1A to 0x1F and 0x28 to 0xFF raise `illegal`. For these opcodes every control output (`alu_sel`, `reg_we`, the strobes and `jump_sel`) is 0, as for a no-op.
- R9: at most one of `mem_rd`, `mem_wr`, `port_in`, `port_out` and any `jump_sel` bit is 1 at a time.
- R10: with REG_OUT=1, every output shows the decode of the word present at the previous rising clock edge. While `rst_n` is low, every output is 0.
- R11: the no-op 0x00 gives no control output and does not raise `illegal`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| instr_word | input | 32 | Fetched instruction word, opcode in the low byte |
| is_long | output | 1 | Long (32-bit) instruction form |
| opcode | output | 8 | Opcode byte |
| reg_a | output | 4 | First register index |
| reg_b | output | 4 | Second register index or port number |
| imm | output | 16 | Immediate for long words, else 0 |
| alu_sel | output | 21 | One-hot ALU operation select |
| reg_we | output | 1 | Write the register named by reg_a |
| mem_rd | output | 1 | Memory read at address in reg_b |
| mem_wr | output | 1 | Memory write of reg_a to address in reg_b |
| port_in | output | 1 | Port read into reg_a |
| port_out | output | 1 | Port write from reg_a |
| jump_sel | output | 8 | One-hot jump kind |
| illegal | output | 1 | Undefined opcode |

## Verification
Length detection and the illegal flag act on the same word in the same cycle. For opcodes 0x28 and above the decoder must report a long word that is also illegal. For 0x1A to 0x1F it must report a short word that is illegal. The bench sweeps every opcode value twice, with varying register, port and immediate fields. A behavioural model in the bench predicts each decode and queues it. The model's prediction is compared field by field on the next cycle against the registered outputs, so both functions are judged on that one word.

// File: rtl/dec_pkg.sv
package dec_pkg;

    localparam int ALU_N = 21;
    localparam int JMP_N = 8;
    localparam int ALU_IW = $clog2(ALU_N);
    localparam int JMP_IW = $clog2(JMP_N);

    localparam logic [7:0] LONG_BASE = 8'h20;

    typedef enum logic [ALU_IW-1:0] {
        ALU_MOVE = 5'd0,
        ALU_AND  = 5'd1,
        ALU_OR   = 5'd2,
        ALU_INV  = 5'd3,
        ALU_XOR  = 5'd4,
        ALU_ADD  = 5'd5,
        ALU_ADDC = 5'd6,
        ALU_SUB  = 5'd7,
        ALU_SUBB = 5'd8,
        ALU_INC  = 5'd9,
        ALU_DEC  = 5'd10,
        ALU_NEG  = 5'd11,
        ALU_SHL  = 5'd12,
        ALU_SHR  = 5'd13,
        ALU_SAL  = 5'd14,
        ALU_SAR  = 5'd15,
        ALU_RCL  = 5'd16,
        ALU_RCR  = 5'd17,
        ALU_CMP  = 5'd18,
        ALU_LINK = 5'd19,
        ALU_IMM  = 5'd20
    } alu_op_e;

    typedef enum logic [JMP_IW-1:0] {
        JK_REG    = 3'd0,
        JK_ALWAYS = 3'd1,
        JK_ZERO   = 3'd2,
        JK_NZERO  = 3'd3,
        JK_LESS   = 3'd4,
        JK_NLESS  = 3'd5,
        JK_GREAT  = 3'd6,
        JK_NGREAT = 3'd7
    } jump_kind_e;

    typedef struct packed {
        logic [ALU_N-1:0] alu_sel;
        logic             reg_we;
        logic             mem_rd;
        logic             mem_wr;
        logic             port_in;
        logic             port_out;
        logic [JMP_N-1:0] jump_sel;
        logic             illegal;
    } ctrl_t;

endpackage

// File: rtl/dec_fields.sv
module dec_fields #(
    parameter int WORD_W = 32,
    parameter int OP_W   = 8,
    parameter int RIDX_W = 4,
    parameter int IMM_W  = 16
) (
    input  logic [WORD_W-1:0] word_i,
    output logic              is_long_o,
    output logic [OP_W-1:0]   opcode_o,
    output logic [RIDX_W-1:0] reg_a_o,
    output logic [RIDX_W-1:0] reg_b_o,
    output logic [IMM_W-1:0]  imm_o
);
    localparam int RA_LO  = OP_W;
    localparam int RB_LO  = OP_W + RIDX_W;
    localparam int IMM_LO = WORD_W - IMM_W;

    always_comb begin
        opcode_o  = word_i[OP_W-1:0];
        reg_a_o   = word_i[RA_LO +: RIDX_W];
        reg_b_o   = word_i[RB_LO +: RIDX_W];
        is_long_o = (word_i[OP_W-1:0] >= OP_W'(dec_pkg::LONG_BASE));
        if (is_long_o) begin
            imm_o = word_i[IMM_LO +: IMM_W];
        end else begin
            imm_o = '0;
        end
    end

endmodule

// File: rtl/dec_ctrl_map.sv
module dec_ctrl_map
    import dec_pkg::*;
#(
    parameter int OP_W = 8
) (
    input  logic [OP_W-1:0] opcode_i,
    output ctrl_t           ctrl_o
);
    alu_op_e    alu_op;
    logic       alu_en;
    jump_kind_e jk;
    logic       jk_en;
    logic       we, rd, wr, pin, pout, bad;

    always_comb begin
        alu_op = ALU_MOVE;
        alu_en = 1'b0;
        jk     = JK_REG;
        jk_en  = 1'b0;
        we     = 1'b0;
        rd     = 1'b0;
        wr     = 1'b0;
        pin    = 1'b0;
        pout   = 1'b0;
        bad    = 1'b0;
        case (opcode_i)
            OP_W'(8'h00): ;
            OP_W'(8'h01): begin alu_op = ALU_MOVE; alu_en = 1'b1; we = 1'b1; end
            OP_W'(8'h02): begin alu_op = ALU_AND;  alu_en = 1'b1; we = 1'b1; end
            OP_W'(8'h03): begin alu_op = ALU_OR;   alu_en = 1'b1; we = 1'b1; end
            OP_W'(8'h04): begin alu_op = ALU_INV;  alu_en = 1'b1; we = 1'b1; end
            OP_W'(8'h05): begin alu_op = ALU_XOR;  alu_en = 1'b1; we = 1'b1; end
            OP_W'(8'h06): begin alu_op = ALU_ADD;  alu_en = 1'b1; we = 1'b1; end
            OP_W'(8'h07): begin alu_op = ALU_SUB;  alu_en = 1'b1; we = 1'b1; end
            OP_W'(8'h08): begin alu_op = ALU_INC;  alu_en = 1'b1; we = 1'b1; end
            OP_W'(8'h09): begin alu_op = ALU_DEC;  alu_en = 1'b1; we = 1'b1; end
            OP_W'(8'h0A): begin alu_op = ALU_SHL;  alu_en = 1'b1; we = 1'b1; end
            OP_W'(8'h0B): begin alu_op = ALU_SHR;  alu_en = 1'b1; we = 1'b1; end
            OP_W'(8'h0C): begin alu_op = ALU_RCL;  alu_en = 1'b1; we = 1'b1; end
            OP_W'(8'h0D): begin alu_op = ALU_RCR;  alu_en = 1'b1; we = 1'b1; end
            OP_W'(8'h0E): begin alu_op = ALU_CMP;  alu_en = 1'b1; end
            OP_W'(8'h0F): begin rd = 1'b1; we = 1'b1; end
            OP_W'(8'h10): begin wr = 1'b1; end
            OP_W'(8'h11): begin pin = 1'b1; we = 1'b1; end
            OP_W'(8'h12): begin pout = 1'b1; end
            OP_W'(8'h13): begin alu_op = ALU_ADDC; alu_en = 1'b1; we = 1'b1; end
            OP_W'(8'h14): begin alu_op = ALU_SUBB; alu_en = 1'b1; we = 1'b1; end
            OP_W'(8'h15): begin alu_op = ALU_NEG;  alu_en = 1'b1; we = 1'b1; end
            OP_W'(8'h16): begin alu_op = ALU_SAL;  alu_en = 1'b1; we = 1'b1; end
            OP_W'(8'h17): begin alu_op = ALU_SAR;  alu_en = 1'b1; we = 1'b1; end
            OP_W'(8'h18): begin jk = JK_REG; jk_en = 1'b1; end
            OP_W'(8'h19): begin alu_op = ALU_LINK; alu_en = 1'b1; we = 1'b1; end
            OP_W'(8'h20): begin alu_op = ALU_IMM;  alu_en = 1'b1; we = 1'b1; end
            OP_W'(8'h21): begin jk = JK_ALWAYS; jk_en = 1'b1; end
            OP_W'(8'h22): begin jk = JK_ZERO;   jk_en = 1'b1; end
            OP_W'(8'h23): begin jk = JK_NZERO;  jk_en = 1'b1; end
            OP_W'(8'h24): begin jk = JK_LESS;   jk_en = 1'b1; end
            OP_W'(8'h25): begin jk = JK_NLESS;  jk_en = 1'b1; end
            OP_W'(8'h26): begin jk = JK_GREAT;  jk_en = 1'b1; end
            OP_W'(8'h27): begin jk = JK_NGREAT; jk_en = 1'b1; end
            default:      bad = 1'b1;
        endcase
    end

    for (genvar g = 0; g < ALU_N; g++) begin : g_alu_hot
        assign ctrl_o.alu_sel[g] = alu_en && (alu_op == alu_op_e'(g));
    end

    for (genvar g = 0; g < JMP_N; g++) begin : g_jmp_hot
        assign ctrl_o.jump_sel[g] = jk_en && (jk == jump_kind_e'(g));
    end

    assign ctrl_o.reg_we   = we;
    assign ctrl_o.mem_rd   = rd;
    assign ctrl_o.mem_wr   = wr;
    assign ctrl_o.port_in  = pin;
    assign ctrl_o.port_out = pout;
    assign ctrl_o.illegal  = bad;

endmodule

// File: rtl/dec_out_stage.sv
module dec_out_stage #(
    parameter int W       = 8,
    parameter bit REG_OUT = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    if (REG_OUT) begin : g_reg
        logic [W-1:0] q_r;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q_r <= '0;
            end else begin
                q_r <= d_i;
            end
        end
        assign q_o = q_r;
    end else begin : g_wire
        logic unused_clk;
        assign unused_clk = clk ^ rst_n;
        assign q_o = d_i;
    end

endmodule

// File: rtl/dual_len_decoder.sv
module dual_len_decoder
    import dec_pkg::*;
#(
    parameter int WORD_W  = 32,
    parameter int OP_W    = 8,
    parameter int RIDX_W  = 4,
    parameter int IMM_W   = 16,
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] instr_word,
    output logic              is_long,
    output logic [OP_W-1:0]   opcode,
    output logic [RIDX_W-1:0] reg_a,
    output logic [RIDX_W-1:0] reg_b,
    output logic [IMM_W-1:0]  imm,
    output logic [ALU_N-1:0]  alu_sel,
    output logic              reg_we,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              port_in,
    output logic              port_out,
    output logic [JMP_N-1:0]  jump_sel,
    output logic              illegal
);
    typedef struct packed {
        logic              is_long;
        logic [OP_W-1:0]   opcode;
        logic [RIDX_W-1:0] reg_a;
        logic [RIDX_W-1:0] reg_b;
        logic [IMM_W-1:0]  imm;
        ctrl_t             ctrl;
    } dec_t;

    localparam int DEC_W = $bits(dec_t);

    dec_t             dec_c;
    dec_t             dec_q;
    logic [DEC_W-1:0] dec_q_v;

    dec_fields #(
        .WORD_W (WORD_W),
        .OP_W   (OP_W),
        .RIDX_W (RIDX_W),
        .IMM_W  (IMM_W)
    ) u_fields (
        .word_i    (instr_word),
        .is_long_o (dec_c.is_long),
        .opcode_o  (dec_c.opcode),
        .reg_a_o   (dec_c.reg_a),
        .reg_b_o   (dec_c.reg_b),
        .imm_o     (dec_c.imm)
    );

    dec_ctrl_map #(
        .OP_W (OP_W)
    ) u_map (
        .opcode_i (dec_c.opcode),
        .ctrl_o   (dec_c.ctrl)
    );

    dec_out_stage #(
        .W       (DEC_W),
        .REG_OUT (REG_OUT)
    ) u_stage (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (dec_c),
        .q_o   (dec_q_v)
    );

    assign dec_q    = dec_t'(dec_q_v);
    assign is_long  = dec_q.is_long;
    assign opcode   = dec_q.opcode;
    assign reg_a    = dec_q.reg_a;
    assign reg_b    = dec_q.reg_b;
    assign imm      = dec_q.imm;
    assign alu_sel  = dec_q.ctrl.alu_sel;
    assign reg_we   = dec_q.ctrl.reg_we;
    assign mem_rd   = dec_q.ctrl.mem_rd;
    assign mem_wr   = dec_q.ctrl.mem_wr;
    assign port_in  = dec_q.ctrl.port_in;
    assign port_out = dec_q.ctrl.port_out;
    assign jump_sel = dec_q.ctrl.jump_sel;
    assign illegal  = dec_q.ctrl.illegal;

    // R3: ALU select never carries two operations
    p_alu_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(alu_sel));

    // R7: jump kind never carries two kinds
    p_jump_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(jump_sel));

    // R8: an undefined opcode drives no control
    p_illegal_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (alu_sel == '0 && !reg_we && !mem_rd && !mem_wr
                     && !port_in && !port_out && jump_sel == '0));

    // R9: side effects are mutually exclusive
    p_one_effect_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({mem_rd, mem_wr, port_in, port_out, |jump_sel}) <= 1);

    // R4: a jump never writes a register
    p_jump_no_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|jump_sel) |-> !reg_we);

    // R2: short words carry no immediate
    p_short_imm_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !is_long |-> (imm == '0));

    // R1: a short illegal word lies in the gap above the last short opcode
    p_short_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (illegal && !is_long) |-> (opcode >= OP_W'(8'h1A) && opcode <= OP_W'(8'h1F)));

endmodule

// File: tb/dual_len_decoder_tb_top.sv
module dual_len_decoder_tb_top;

    typedef struct packed {
        logic        is_long;
        logic [7:0]  opcode;
        logic [3:0]  reg_a;
        logic [3:0]  reg_b;
        logic [15:0] imm;
        logic [20:0] alu_sel;
        logic        reg_we;
        logic        mem_rd;
        logic        mem_wr;
        logic        port_in;
        logic        port_out;
        logic [7:0]  jump_sel;
        logic        illegal;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr_word = '0;
    logic        is_long, reg_we, mem_rd, mem_wr, port_in, port_out, illegal;
    logic [7:0]  opcode;
    logic [3:0]  reg_a, reg_b;
    logic [15:0] imm;
    logic [20:0] alu_sel;
    logic [7:0]  jump_sel;

    int checks = 0;
    int failures = 0;
    exp_t q[$];
    logic [31:0] rng = 32'h1234_5678;

    always #2.5 clk = ~clk;

    dual_len_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .instr_word(instr_word),
        .is_long(is_long), .opcode(opcode), .reg_a(reg_a), .reg_b(reg_b),
        .imm(imm), .alu_sel(alu_sel), .reg_we(reg_we), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .port_in(port_in), .port_out(port_out),
        .jump_sel(jump_sel), .illegal(illegal)
    );

    function automatic exp_t model(input logic [31:0] w);
        exp_t e;
        int op;
        int ai;
        int ji;
        e = '0;
        op = int'(w[7:0]);
        e.opcode  = w[7:0];
        e.reg_a   = w[11:8];
        e.reg_b   = w[15:12];
        e.is_long = (op >= 32);
        e.imm     = e.is_long ? w[31:16] : 16'h0;
        ai = -1;
        case (op)
            1: ai = 0;   2: ai = 1;   3: ai = 2;   4: ai = 3;   5: ai = 4;
            6: ai = 5;   19: ai = 6;  7: ai = 7;   20: ai = 8;  8: ai = 9;
            9: ai = 10;  21: ai = 11; 10: ai = 12; 11: ai = 13; 22: ai = 14;
            23: ai = 15; 12: ai = 16; 13: ai = 17; 14: ai = 18; 25: ai = 19;
            32: ai = 20;
            default: ai = -1;
        endcase
        if (ai >= 0) e.alu_sel[ai] = 1'b1;
        ji = -1;
        if (op == 24) ji = 0;
        else if (op >= 33 && op <= 39) ji = op - 32;
        if (ji >= 0) e.jump_sel[ji] = 1'b1;
        e.mem_rd   = (op == 15);
        e.mem_wr   = (op == 16);
        e.port_in  = (op == 17);
        e.port_out = (op == 18);
        e.illegal  = (op >= 26 && op <= 31) || (op >= 40);
        e.reg_we   = !e.illegal && (op <= 39) && !(op == 0 || op == 14 || op == 16 || op == 18 || op == 24 || op >= 33);
        return e;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", req, act, exp_v);
        end
    endtask

    task automatic compare(input exp_t e);
        chk("R1 is_long", 32'(is_long), 32'(e.is_long));
        chk("R2 fields", {opcode, reg_a, reg_b, imm}, {e.opcode, e.reg_a, e.reg_b, e.imm});
        chk("R3 alu_sel", 32'(alu_sel), 32'(e.alu_sel));
        chk("R4 reg_we", 32'(reg_we), 32'(e.reg_we));
        chk("R5 memory", {30'h0, mem_rd, mem_wr}, {30'h0, e.mem_rd, e.mem_wr});
        chk("R6 port", {30'h0, port_in, port_out}, {30'h0, e.port_in, e.port_out});
        chk("R7 jump_sel", 32'(jump_sel), 32'(e.jump_sel));
        chk("R8 illegal", 32'(illegal), 32'(e.illegal));
        chk("R9 exclusive", 32'($countones({mem_rd, mem_wr, port_in, port_out, |jump_sel}) <= 1), 32'h1);
        if (e.opcode == 8'h00) begin
            // R11: no-op is quiet and legal
            chk("R11 nop", {alu_sel, jump_sel, reg_we, mem_rd, mem_wr, port_in, port_out, illegal}, '0);
        end
    endtask

    task automatic step(input logic [31:0] w);
        @(negedge clk);
        if (q.size() > 0) compare(q.pop_front());
        instr_word = w;
        q.push_back(model(w));
    endtask

    function automatic logic [31:0] next_rng(input logic [31:0] s);
        logic [31:0] x;
        x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired act=running exp=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : stim
        instr_word = 32'hFFFF_FF06;
        repeat (3) @(negedge clk);
        // R10: reset holds every output at zero
        chk("R10 reset", {31'h0, is_long} | {opcode, reg_a, reg_b, imm}, 32'h0);
        chk("R10 reset ctrl", {alu_sel, reg_we, mem_rd, mem_wr, port_in, port_out, illegal}, 32'h0);
        chk("R10 reset jump", 32'(jump_sel), 32'h0);
        rst_n = 1'b1;
        q.push_back(model(instr_word));
        // R10: each word is seen one edge later
        for (int pass = 0; pass < 2; pass++) begin
            for (int op = 0; op < 256; op++) begin
                rng = next_rng(rng);
                step({rng[31:8], 8'(op)});
            end
        end
        // corner words: boundaries of the short/long split and the gaps
        step(32'hABCD_F01F);
        step(32'h5A5A_0020);
        step(32'hFFFF_FF19);
        step(32'h0001_0F28);
        step(32'h8000_2127);
        step(32'h0000_0000);
        step(32'h0000_0000);
        @(negedge clk);
        if (q.size() > 0) compare(q.pop_front());
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule